// File: doc/BRIEF.md
# Per-Bank Row-Hit-First Request Selector

This block keeps the pending memory requests of a controller, one arrival-ordered queue per bank. Each request carries a bank index, a row address, a read/write flag and a tag that identifies it to the rest of the controller. A bank machine asks for work by presenting its bank index, whether its bank is activated or precharged, and the row currently open. The block answers in the same cycle with the tag of the request to serve next. It also reports whether another request is waiting on that bank, and whether another queued request targets the same row. The bank machine uses these two flags to decide between keeping the row open and closing it.

With the default row-first policy, an activated bank is served with its oldest request that hits the open row. When the bank is precharged, or no queued request hits, the oldest request is served instead. Requests leave a queue by tag, from any position, and the entries left behind keep their order. A parameter selects an in-order variant instead. In that variant only the head is ever served or removed, and the row-hit flag looks at the second entry only. Admission control, DRAM timing and command generation belong to other blocks.

Top module: `bsel_top`

## Requirements
- R1: Each bank has its own queue. Enqueueing to or removing from one bank never changes the selection reported for another bank.
- R2: In the row-first policy, with `qry_active`=1, the selection is the oldest entry of the queried bank whose row equals `qry_row`.
- R3: In the row-first policy, when `qry_active`=0 or no entry hits `qry_row`, the selection is the oldest entry of the queried bank.
- R4: When the queried bank's queue is empty, `sel_valid`=0, `sel_tag`=0, `more_req`=0 and `more_hit`=0.
- R5: In the row-first policy, a removal deletes the oldest entry of `rm_bank` whose tag equals `rm_tag`, from any position, and the other entries keep their arrival order. A removal whose tag matches nothing has no effect.
- R6: `more_req`=1 exactly when the queried bank holds two or more entries.
- R7: In the row-first policy, `more_hit`=1 exactly when two or more entries of the queried bank have row equal to `qry_row`, whatever the value of `qry_active`.
- R8: In the in-order policy (`POLICY`=POL_IN_ORDER), the selection is always the head of the queue. A removal takes the head whatever `rm_tag` is, and `more_hit`=1 exactly when a second entry exists and its row equals `qry_row`.
- R9: An enqueue to a bank whose queue already holds `DEPTH` entries drives `enq_overflow`=1 in that same cycle, and the request is dropped.
- R10: The selection outputs follow the query inputs combinationally. An enqueue or a removal takes effect at the next rising clock edge, and the removal is applied before the append when both hit the same bank in one cycle. A synchronous active-high `rst` empties every queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_bank | input | BANK_W | Bank of the new request |
| enq_row | input | BSEL_ROW_W | Row of the new request |
| enq_is_wr | input | 1 | 1 for write, 0 for read |
| enq_tag | input | BSEL_TAG_W | Tag of the new request |
| enq_overflow | output | 1 | Enqueue hit a full queue and was dropped |
| rm_valid | input | 1 | Removal strobe |
| rm_bank | input | BANK_W | Bank to remove from |
| rm_tag | input | BSEL_TAG_W | Tag to remove (ignored in the in-order policy) |
| qry_bank | input | BANK_W | Bank being queried |
| qry_active | input | 1 | 1 if the queried bank is activated, 0 if precharged |
| qry_row | input | BSEL_ROW_W | Open row of the queried bank |
| sel_valid | output | 1 | A request is selected |
| sel_tag | output | BSEL_TAG_W | Tag of the selected request |
| more_hit | output | 1 | Another queued request targets `qry_row` |
| more_req | output | 1 | Two or more requests wait on the queried bank |

## Verification
The bench goes after row hits that sit behind an older miss. A design that simply served the head would return the wrong tag there, and one that took the newest hit would pick the later of two hits. It removes a tag from the middle of a queue and checks the order that remains. A compaction that shifted the wrong side would surface as a stale or duplicated tag. It also sends a removal whose tag matches nothing, and a removal and an enqueue on the same bank in one cycle, where a wrong ordering would lose the new entry. The in-order variant receives the same stimulus, so a row-hit search leaking into it, or a removal that honours the tag, gives a different head. Finally, an enqueue to a full queue must flag overflow and leave no trace; the bench drains the bank and checks that it ends empty.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    parameter int unsigned BSEL_ROW_W = 12;
    parameter int unsigned BSEL_TAG_W = 6;

    typedef enum logic {
        POL_ROW_FIRST = 1'b0,
        POL_IN_ORDER  = 1'b1
    } policy_e;

    typedef struct packed {
        logic [BSEL_ROW_W-1:0] row;
        logic                  is_wr;
        logic [BSEL_TAG_W-1:0] tag;
    } bsel_req_t;

    function automatic int unsigned cnt_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int unsigned idx_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/bsel_bank_queue.sv
module bsel_bank_queue
    import bsel_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter policy_e     POLICY = POL_ROW_FIRST
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push_i,
    input  bsel_req_t                      push_req_i,
    input  logic                           rm_i,
    input  logic [BSEL_TAG_W-1:0]          rm_tag_i,
    output bsel_req_t                      ent_o [DEPTH],
    output logic [cnt_width(DEPTH)-1:0]    cnt_o,
    output logic                           full_o
);
    localparam int unsigned CNT_W = cnt_width(DEPTH);
    localparam int unsigned IDX_W = idx_width(DEPTH);

    bsel_req_t         ent_q [DEPTH];
    bsel_req_t         ent_n [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_n;
    logic              rm_hit;
    logic [IDX_W-1:0]  rm_idx;
    logic              push_ok;

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign cnt_o   = cnt_q;
    assign ent_o   = ent_q;

    // Locate the entry a removal deletes.
    generate
        if (POLICY == POL_IN_ORDER) begin : g_rm_head
            always_comb begin
                rm_hit = rm_i && (cnt_q != '0);
                rm_idx = '0;
            end
        end else begin : g_rm_tag
            always_comb begin
                rm_hit = 1'b0;
                rm_idx = '0;
                for (int i = DEPTH - 1; i >= 0; i--) begin
                    if (rm_i && (CNT_W'(i) < cnt_q) && (ent_q[i].tag == rm_tag_i)) begin
                        rm_hit = 1'b1;
                        rm_idx = IDX_W'(i);
                    end
                end
            end
        end
    endgenerate

    // Compact over the removed slot first, then append at the new tail.
    always_comb begin
        ent_n = ent_q;
        cnt_n = cnt_q;
        if (rm_hit) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= rm_idx) begin
                    ent_n[i] = ent_q[i+1];
                end
            end
            cnt_n = cnt_q - CNT_W'(1);
        end
        if (push_ok) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == cnt_n) begin
                    ent_n[i] = push_req_i;
                end
            end
            cnt_n = cnt_n + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_n;
            ent_q <= ent_n;
        end
    end

endmodule

// File: rtl/bsel_pick.sv
module bsel_pick
    import bsel_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter policy_e     POLICY = POL_ROW_FIRST
) (
    input  bsel_req_t                      ent_i [DEPTH],
    input  logic [cnt_width(DEPTH)-1:0]    cnt_i,
    input  logic                           active_i,
    input  logic [BSEL_ROW_W-1:0]          row_i,
    output logic                           sel_valid_o,
    output logic [BSEL_TAG_W-1:0]          sel_tag_o,
    output logic                           more_hit_o,
    output logic                           more_req_o
);
    localparam int unsigned CNT_W = cnt_width(DEPTH);
    localparam int unsigned IDX_W = idx_width(DEPTH);

    logic [DEPTH-1:0] hit;
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = (CNT_W'(i) < cnt_i) && (ent_i[i].row == row_i);
        end
    end

    assign sel_valid_o = (cnt_i != '0);
    assign more_req_o  = (cnt_i > CNT_W'(1));
    assign sel_tag_o   = sel_valid_o ? ent_i[sel_idx].tag : '0;

    generate
        if (POLICY == POL_IN_ORDER) begin : g_in_order
            assign sel_idx = '0;
            if (DEPTH > 1) begin : g_second
                assign more_hit_o = hit[1];
            end else begin : g_single
                assign more_hit_o = 1'b0;
            end
        end else begin : g_row_first
            logic any_hit;
            logic [IDX_W-1:0] first_hit;
            always_comb begin
                any_hit   = 1'b0;
                first_hit = '0;
                for (int i = DEPTH - 1; i >= 0; i--) begin
                    if (hit[i]) begin
                        any_hit   = 1'b1;
                        first_hit = IDX_W'(i);
                    end
                end
            end
            assign sel_idx    = (active_i && any_hit) ? first_hit : '0;
            assign more_hit_o = ($countones(hit) > 1);
        end
    endgenerate

endmodule

// File: rtl/bsel_top.sv
module bsel_top
    import bsel_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned DEPTH     = 4,
    parameter policy_e     POLICY    = POL_ROW_FIRST,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enq_valid,
    input  logic [BANK_W-1:0]     enq_bank,
    input  logic [BSEL_ROW_W-1:0] enq_row,
    input  logic                  enq_is_wr,
    input  logic [BSEL_TAG_W-1:0] enq_tag,
    output logic                  enq_overflow,
    input  logic                  rm_valid,
    input  logic [BANK_W-1:0]     rm_bank,
    input  logic [BSEL_TAG_W-1:0] rm_tag,
    input  logic [BANK_W-1:0]     qry_bank,
    input  logic                  qry_active,
    input  logic [BSEL_ROW_W-1:0] qry_row,
    output logic                  sel_valid,
    output logic [BSEL_TAG_W-1:0] sel_tag,
    output logic                  more_hit,
    output logic                  more_req
);
    localparam int unsigned CNT_W = cnt_width(DEPTH);

    bsel_req_t        new_req;
    bsel_req_t        bank_ent [NUM_BANKS][DEPTH];
    logic [CNT_W-1:0] bank_cnt [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_full;
    bsel_req_t        q_ent [DEPTH];
    logic [CNT_W-1:0] q_cnt;

    assign new_req = '{row: enq_row, is_wr: enq_is_wr, tag: enq_tag};

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            bsel_bank_queue #(
                .DEPTH  (DEPTH),
                .POLICY (POLICY)
            ) u_queue (
                .clk        (clk),
                .rst        (rst),
                .push_i     (enq_valid && (enq_bank == BANK_W'(b))),
                .push_req_i (new_req),
                .rm_i       (rm_valid && (rm_bank == BANK_W'(b))),
                .rm_tag_i   (rm_tag),
                .ent_o      (bank_ent[b]),
                .cnt_o      (bank_cnt[b]),
                .full_o     (bank_full[b])
            );
        end
    endgenerate

    assign enq_overflow = enq_valid && bank_full[enq_bank];

    always_comb begin
        q_ent = bank_ent[qry_bank];
        q_cnt = bank_cnt[qry_bank];
    end

    bsel_pick #(
        .DEPTH  (DEPTH),
        .POLICY (POLICY)
    ) u_pick (
        .ent_i       (q_ent),
        .cnt_i       (q_cnt),
        .active_i    (qry_active),
        .row_i       (qry_row),
        .sel_valid_o (sel_valid),
        .sel_tag_o   (sel_tag),
        .more_hit_o  (more_hit),
        .more_req_o  (more_req)
    );

endmodule

// File: rtl/bsel_checker.sv
module bsel_checker
    import bsel_pkg::*;
#(
    parameter int unsigned BANK_W = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  enq_valid,
    input logic                  rm_valid,
    input logic [BANK_W-1:0]     qry_bank,
    input logic                  qry_active,
    input logic [BSEL_ROW_W-1:0] qry_row,
    input logic                  sel_valid,
    input logic [BSEL_TAG_W-1:0] sel_tag,
    input logic                  more_hit,
    input logic                  more_req,
    input logic                  enq_overflow
);

    p_empty_after_reset_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sel_valid && !more_req && !more_hit));

    p_more_req_has_sel_r6: assert property (@(posedge clk) disable iff (rst)
        more_req |-> sel_valid);

    p_more_hit_has_req_r7: assert property (@(posedge clk) disable iff (rst)
        more_hit |-> more_req);

    p_ovf_needs_enq_r9: assert property (@(posedge clk) disable iff (rst)
        enq_overflow |-> enq_valid);

    p_no_ovf_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !enq_overflow);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(!enq_valid && !rm_valid && !rst) && $stable(qry_bank)
         && $stable(qry_active) && $stable(qry_row))
        |-> ($stable(sel_valid) && $stable(sel_tag) && $stable(more_hit) && $stable(more_req)));

endmodule

bind bsel_top bsel_checker #(.BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enq_valid    (enq_valid),
    .rm_valid     (rm_valid),
    .qry_bank     (qry_bank),
    .qry_active   (qry_active),
    .qry_row      (qry_row),
    .sel_valid    (sel_valid),
    .sel_tag      (sel_tag),
    .more_hit     (more_hit),
    .more_req     (more_req),
    .enq_overflow (enq_overflow)
);

// File: tb/sim_bsel_top.sv
module sim_bsel_top;
    import bsel_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int QD = 4;
    localparam int BW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enq_valid = 1'b0;
    logic [BW-1:0] enq_bank = '0;
    logic [BSEL_ROW_W-1:0] enq_row = '0;
    logic enq_is_wr = 1'b0;
    logic [BSEL_TAG_W-1:0] enq_tag = '0;
    logic rm_valid = 1'b0;
    logic [BW-1:0] rm_bank = '0;
    logic [BSEL_TAG_W-1:0] rm_tag = '0;
    logic [BW-1:0] qry_bank = '0;
    logic qry_active = 1'b0;
    logic [BSEL_ROW_W-1:0] qry_row = '0;

    logic a_valid, a_hit, a_req, a_ovf;
    logic [BSEL_TAG_W-1:0] a_tag;
    logic b_valid, b_hit, b_req, b_ovf;
    logic [BSEL_TAG_W-1:0] b_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsel_top #(.NUM_BANKS(NB), .DEPTH(QD), .POLICY(POL_ROW_FIRST)) u0 (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_is_wr(enq_is_wr), .enq_tag(enq_tag),
        .enq_overflow(a_ovf), .rm_valid(rm_valid), .rm_bank(rm_bank),
        .rm_tag(rm_tag), .qry_bank(qry_bank), .qry_active(qry_active),
        .qry_row(qry_row), .sel_valid(a_valid), .sel_tag(a_tag),
        .more_hit(a_hit), .more_req(a_req));

    bsel_top #(.NUM_BANKS(NB), .DEPTH(QD), .POLICY(POL_IN_ORDER)) u1 (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_bank(enq_bank),
        .enq_row(enq_row), .enq_is_wr(enq_is_wr), .enq_tag(enq_tag),
        .enq_overflow(b_ovf), .rm_valid(rm_valid), .rm_bank(rm_bank),
        .rm_tag(rm_tag), .qry_bank(qry_bank), .qry_active(qry_active),
        .qry_row(qry_row), .sel_valid(b_valid), .sel_tag(b_tag),
        .more_hit(b_hit), .more_req(b_req));

    typedef struct {
        int    inst;
        bit    is_ovf;
        bit    v;
        int    tag;
        bit    mh;
        bit    mr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Monitor: pops expectations and compares at the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            logic v, mh, mr, ov;
            int t;
            e = exp_q.pop_front();
            v  = (e.inst == 0) ? a_valid : b_valid;
            mh = (e.inst == 0) ? a_hit   : b_hit;
            mr = (e.inst == 0) ? a_req   : b_req;
            ov = (e.inst == 0) ? a_ovf   : b_ovf;
            t  = (e.inst == 0) ? int'(a_tag) : int'(b_tag);
            n_cmp++;
            if (e.is_ovf) begin
                if (ov !== e.v) begin
                    n_bad++;
                    $display("FAIL %s u%0d overflow: got %0b expected %0b", e.req, e.inst, ov, e.v);
                end
            end else if (v !== e.v || t != e.tag || mh !== e.mh || mr !== e.mr) begin
                n_bad++;
                $display("FAIL %s u%0d: got valid=%0b tag=%0d hit=%0b req=%0b expected valid=%0b tag=%0d hit=%0b req=%0b",
                         e.req, e.inst, v, t, mh, mr, e.v, e.tag, e.mh, e.mr);
            end
        end
    end

    task automatic push_sel(input int inst, input bit v, input int tag,
                            input bit mh, input bit mr, input string req);
        exp_t e;
        e.inst = inst; e.is_ovf = 0; e.v = v; e.tag = tag;
        e.mh = mh; e.mr = mr; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_ovf(input int inst, input bit v, input string req);
        exp_t e;
        e.inst = inst; e.is_ovf = 1; e.v = v; e.tag = 0;
        e.mh = 0; e.mr = 0; e.req = req;
        exp_q.push_back(e);
    endtask

    // Query a bank and expect results from both policies in this cycle.
    task automatic chk(input int bank, input bit act, input int row,
                       input bit av, input int at, input bit ah, input bit ar,
                       input bit bv, input int bt, input bit bh, input bit br,
                       input string req);
        qry_bank = BW'(bank);
        qry_active = act;
        qry_row = BSEL_ROW_W'(row);
        push_sel(0, av, at, ah, ar, req);
        push_sel(1, bv, bt, bh, br, req);
        @(posedge clk); #1;
    endtask

    task automatic enq(input int bank, input int row, input int tag);
        enq_valid = 1'b1;
        enq_bank = BW'(bank);
        enq_row = BSEL_ROW_W'(row);
        enq_is_wr = tag[0];
        enq_tag = BSEL_TAG_W'(tag);
        @(posedge clk); #1;
        enq_valid = 1'b0;
    endtask

    task automatic rmv(input int bank, input int tag);
        rm_valid = 1'b1;
        rm_bank = BW'(bank);
        rm_tag = BSEL_TAG_W'(tag);
        @(posedge clk); #1;
        rm_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R4 R10: reset leaves every queue empty
        chk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 R10 reset empty");

        enq(0, 5, 1);
        enq(0, 7, 2);
        enq(0, 5, 3);
        enq(0, 9, 4);
        enq(1, 5, 10);

        // R2: hit behind an older miss; R8: in-order serves head, second row 7 hits
        chk(0, 1, 7, 1, 2, 0, 1, 1, 1, 1, 1, "R2 R8 hit behind miss");
        // R2 R7: two hits on row 5, oldest chosen
        chk(0, 1, 5, 1, 1, 1, 1, 1, 1, 0, 1, "R2 R7 two hits");
        // R3: precharged serves oldest; R7 flag independent of state
        chk(0, 0, 7, 1, 1, 0, 1, 1, 1, 1, 1, "R3 R7 precharged");
        // R3: activated but no hit
        chk(0, 1, 3, 1, 1, 0, 1, 1, 1, 0, 1, "R3 no hit");
        // R1 R6: bank 1 independent, single entry
        chk(1, 1, 5, 1, 10, 0, 0, 1, 10, 0, 0, "R1 R6 single entry");
        // R4 R1: untouched bank empty
        chk(2, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R4 R1 empty bank");

        // R9: enqueue to full bank 0 raises overflow in the same cycle
        enq_valid = 1'b1; enq_bank = 2'd0; enq_row = 12'd1; enq_tag = 6'd5; enq_is_wr = 1'b0;
        push_ovf(0, 1, "R9 overflow");
        push_ovf(1, 1, "R9 overflow");
        @(posedge clk); #1;
        enq_valid = 1'b0;
        chk(0, 1, 1, 1, 1, 0, 1, 1, 1, 0, 1, "R9 dropped entry not visible");

        // R5: remove tag 2 from the middle; R8: in-order removes head tag 1
        rmv(0, 2);
        chk(0, 1, 7, 1, 1, 0, 1, 1, 2, 0, 1, "R5 R8 middle removal");
        chk(0, 1, 9, 1, 4, 0, 1, 1, 2, 0, 1, "R5 order kept");

        // R5: unmatched tag has no effect; R8: in-order pops head anyway
        rmv(0, 63);
        chk(0, 1, 5, 1, 1, 1, 1, 1, 3, 0, 1, "R5 R8 unmatched tag");

        // R10: removal and enqueue on the same bank in one cycle
        enq_valid = 1'b1; enq_bank = 2'd0; enq_row = 12'd9; enq_tag = 6'd6; enq_is_wr = 1'b0;
        rm_valid = 1'b1; rm_bank = 2'd0; rm_tag = 6'd1;
        push_ovf(0, 0, "R9 R10 no overflow after removal");
        push_ovf(1, 0, "R9 R10 no overflow after removal");
        @(posedge clk); #1;
        enq_valid = 1'b0; rm_valid = 1'b0;
        chk(0, 1, 9, 1, 4, 1, 1, 1, 4, 1, 1, "R10 R7 R8 simultaneous");

        // R5 R9: drain bank 0; dropped tag 5 must not remain
        rmv(0, 4);
        rmv(0, 3);
        rmv(0, 6);
        chk(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R5 R9 R6 drained");

        // R1: bank 1 unaffected by all bank 0 traffic
        chk(1, 0, 0, 1, 10, 0, 0, 1, 10, 0, 0, "R1 bank 1 kept");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule